// File: doc/BRIEF.md
# Leap-Forward Random Bit Stream Generator

This block produces uniformly distributed pseudo-random bits from a 129-bit Fibonacci shift register whose feedback follows the primitive trinomial x^129 + x^124 + 1. The register never holds the all-zero value, so it runs through all 2^129-1 nonzero states before repeating. At 40 MHz that takes far longer than any practical run. Each accepted advance moves the register forward by `STEPS` single shifts in one clock. The combined next-state network is built at elaboration by chaining `STEPS` copies of the one-shift function. If `STEPS` shares no factor with 2^129-1, the period stays the same.

The `STEPS` bits created during one advance leave as a single word on a valid/ready stream. The most recently created bit is in the most significant position. Because only one genuinely new bit exists per single shift, the word holds exactly the fresh bits and no stale register copies. The consumer applies back-pressure by holding `out_ready` low. While it does, the word stays frozen and the register does not move. A seed port reloads the register so that a sequence can be replayed exactly. A zero seed is replaced by a fixed nonzero constant. A seed load wins over a request to advance in the same cycle.

Top module: `lfsr_leap_gen`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and the register holds the fallback constant (value 1, only bit 0 set).
- R2: One single shift takes the state s, computes b = s[128] XOR s[123], moves s one place toward the MSB and puts b into bit 0.
- R3: An accepted advance applies exactly `STEPS` single shifts (default 8) to the register in one clock.
- R4: In the output word, bit `STEPS-1` holds the last bit created during the advance and bit 0 holds the first. Each bit sits one place below the bit created after it.
- R5: An advance is accepted at a rising edge when `en` is 1, `seed_load` is 0, and either `out_valid` is 0 or `out_ready` is 1. `out_valid` is 1 in the cycle after an accepted advance. Without `en`, `out_valid` stays 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_valid` hold their values and the register does not advance, whatever `en` does.
- R7: `seed_load` takes priority. The register takes the seed, `out_valid` goes to 0, any pending word is discarded and `en` is ignored in that cycle.
- R8: Loading an all-zero seed loads the fallback constant 1 instead.
- R9: Loading the same seed twice yields the same sequence of output words.
- R10: The register is never all zeros.
- R11: `out_bit` always equals bit `STEPS-1` of `out_word`, which is the newest bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed` into the register this cycle |
| seed | input | 129 | Seed value; zero is replaced by 1 |
| en | input | 1 | Request an advance of `STEPS` shifts |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | `out_word` holds an unconsumed word |
| out_word | output | STEPS | Fresh bits, newest at the MSB |
| out_bit | output | 1 | The newest fresh bit |

## Verification
A scoreboard model advances its own copy of the register one shift at a time and assembles each word from the shifted-in bits. A tap at the wrong position, a missing shift, or a reversed word would therefore break the comparison within a few words. The stall cases toggle `out_ready` while `en` stays high. A design that advanced under back-pressure would skip words, and one that let the word drift would change the value the scoreboard holds. Seed loads are issued with `en` high, with a zero seed, and twice with the same seed. A design that let the advance win would be one word ahead, a design that admitted zero would emit nothing but zeros, and a non-repeatable load would give differing first words.

// File: rtl/lfsr_leap_pkg.sv
package lfsr_leap_pkg;
  // Register update chosen for a cycle
  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_SEED    = 2'd1,
    UPD_ADVANCE = 2'd2,
    UPD_DRAIN   = 2'd3
  } upd_e;
endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int unsigned W      = 129,
  parameter int unsigned TAP_LO = 124
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         new_bit
);
  // Feedback from the top stage and the inner tap of the trinomial
  assign new_bit = cur[W-1] ^ cur[TAP_LO-1];
  assign nxt     = {cur[W-2:0], new_bit};
endmodule

// File: rtl/lfsr_leap.sv
module lfsr_leap #(
  parameter int unsigned W      = 129,
  parameter int unsigned TAP_LO = 124,
  parameter int unsigned STEPS  = 8
) (
  input  logic [W-1:0]     cur,
  output logic [W-1:0]     nxt,
  output logic [STEPS-1:0] fresh
);
  // chain[k] is the state after k single shifts
  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = cur;

  for (genvar k = 0; k < STEPS; k++) begin : g_stage
    // stage k creates the (k+1)-th bit; later bits land higher in fresh
    lfsr_step #(.W(W), .TAP_LO(TAP_LO)) u_step (
      .cur     (chain[k]),
      .nxt     (chain[k+1]),
      .new_bit (fresh[k])
    );
  end

  assign nxt = chain[STEPS];
endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_leap_pkg::*;
(
  input  logic seed_load,
  input  logic en,
  input  logic out_valid,
  input  logic out_ready,
  output upd_e upd
);
  logic slot_free;
  assign slot_free = !out_valid || out_ready;

  always_comb begin
    if (seed_load)             upd = UPD_SEED;
    else if (en && slot_free)  upd = UPD_ADVANCE;
    else if (out_valid && out_ready) upd = UPD_DRAIN;
    else                       upd = UPD_HOLD;
  end
endmodule

// File: rtl/lfsr_leap_gen.sv
module lfsr_leap_gen
  import lfsr_leap_pkg::*;
#(
  parameter int unsigned W      = 129,
  parameter int unsigned TAP_LO = 124,
  parameter int unsigned STEPS  = 8,
  parameter logic [W-1:0] FALLBACK = W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [W-1:0]     seed,
  input  logic             en,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [STEPS-1:0] out_word,
  output logic             out_bit
);
  localparam int unsigned MSB = STEPS - 1;

  logic [W-1:0]     state_q;
  logic [W-1:0]     leap_nxt;
  logic [W-1:0]     seed_eff;
  logic [STEPS-1:0] fresh;
  logic [STEPS-1:0] word_q;
  logic             valid_q;
  upd_e             upd;

  lfsr_leap #(.W(W), .TAP_LO(TAP_LO), .STEPS(STEPS)) u_leap (
    .cur   (state_q),
    .nxt   (leap_nxt),
    .fresh (fresh)
  );

  lfsr_ctrl u_ctrl (
    .seed_load (seed_load),
    .en        (en),
    .out_valid (valid_q),
    .out_ready (out_ready),
    .upd       (upd)
  );

  // The zero state would lock the register; substitute a nonzero one
  assign seed_eff = (seed == '0) ? FALLBACK : seed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FALLBACK;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      unique case (upd)
        UPD_SEED: begin
          state_q <= seed_eff;
          valid_q <= 1'b0;
        end
        UPD_ADVANCE: begin
          state_q <= leap_nxt;
          word_q  <= fresh;
          valid_q <= 1'b1;
        end
        UPD_DRAIN: valid_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;
  assign out_bit   = word_q[MSB];

  // Register must never reach the lock-up state
  assert_state_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // Stalled word is frozen and stays offered
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !seed_load |=> out_valid && $stable(out_word));

  // Accepted advance presents a word next cycle
  assert_valid_after_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !seed_load && (!out_valid || out_ready) |=> out_valid);

  // Seed load withdraws any word, even with en high
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !out_valid);

  // Zero seed becomes the fallback constant
  assert_zero_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && seed == '0 |=> state_q == FALLBACK);
endmodule

// File: tb/lfsr_leap_gen_tb.sv
module lfsr_leap_gen_tb;
  localparam int W = 129;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         seed_load;
  logic [W-1:0] seed;
  logic         en;
  logic         out_ready;
  logic         out_valid;
  logic [N-1:0] out_word;
  logic         out_bit;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] model;
  logic [N-1:0] expq [$];
  logic [N-1:0] prev_word;
  logic         prev_stall = 1'b0;
  logic         cap_en = 1'b0;
  int           cap_set = 0;
  int           cap_n = 0;
  logic [N-1:0] cap [2][4];

  localparam logic [W-1:0] SEED_A = {1'b1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210};
  localparam logic [W-1:0] SEED_B = {1'b0, 128'hdead_beef_0f0f_1234_a5a5_5a5a_c3c3_0001};

  always #5 clk = ~clk;

  lfsr_leap_gen u_dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed), .en(en),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word), .out_bit(out_bit)
  );

  // Reference: one shift at a time, each new bit enters the word from the top
  function automatic logic [N-1:0] advance(inout logic [W-1:0] s);
    logic [N-1:0] w = '0;
    for (int k = 0; k < N; k++) begin
      logic nb;
      nb = s[W-1] ^ s[123];
      s  = {s[W-2:0], nb};
      w  = {nb, w[N-1:1]};
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes expected words
  task automatic drive(input logic e, input logic r, input logic ld, input logic [W-1:0] sd);
    @(negedge clk);
    en = e; out_ready = ld ? 1'b0 : r; seed_load = ld; seed = sd;
    if (ld) begin
      expq.delete();
      model = (sd == '0) ? W'(1) : sd;
    end else if (e && (!out_valid || r)) begin
      expq.push_back(advance(model));
    end
    @(posedge clk);
  endtask

  // Monitor: pops at each handshake, checks stalls and the single-bit output
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_word == prev_word, "R6 stall hold", out_word, prev_word);
      if (out_valid) begin
        check(out_bit == out_word[N-1], "R11 newest bit", {7'd0, out_bit}, {7'd0, out_word[N-1]});
        if (out_ready) begin
          if (expq.size() == 0) begin
            check(1'b0, "R5 unexpected word", out_word, '0);
          end else begin
            logic [N-1:0] e;
            e = expq.pop_front();
            check(out_word == e, "R2 R3 R4 word", out_word, e);
            if (cap_en && cap_n < 4) begin
              cap[cap_set][cap_n] = out_word;
              cap_n++;
            end
          end
        end
      end
      prev_stall = out_valid && !out_ready && !seed_load;
      prev_word  = out_word;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; out_ready = 1'b0; seed_load = 1'b0; seed = '0;
    model = W'(1);
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R1 reset valid", {7'd0, out_valid}, '0);
    rst_n = 1'b1;
    // R5: idle without en keeps valid low
    repeat (3) drive(1'b0, 1'b1, 1'b0, '0);
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R5 idle valid", {7'd0, out_valid}, '0);
    // R1: stream from the reset constant, consumer always ready
    repeat (30) drive(1'b1, 1'b1, 1'b0, '0);
    @(negedge clk); #2;
    check(out_valid == 1'b1, "R5 valid after en", {7'd0, out_valid}, 8'd1);
    // R7: load with en high, then back-pressure pattern (R6)
    cap_en = 1'b1; cap_set = 0; cap_n = 0;
    drive(1'b1, 1'b1, 1'b1, SEED_A);
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R7 load clears valid", {7'd0, out_valid}, '0);
    for (int i = 0; i < 40; i++) drive(1'b1, (i % 3) != 1, 1'b0, '0);
    // R8: zero seed behaves like seed 1
    drive(1'b0, 1'b0, 1'b1, '0);
    for (int i = 0; i < 30; i++) drive(1'b1, (i % 4) != 0, 1'b0, '0);
    // R9: replay SEED_A and compare the first words
    cap_set = 1; cap_n = 0;
    drive(1'b1, 1'b1, 1'b1, SEED_A);
    repeat (10) drive(1'b1, 1'b1, 1'b0, '0);
    cap_en = 1'b0;
    for (int i = 0; i < 4; i++)
      check(cap[0][i] == cap[1][i], "R9 replay", cap[1][i], cap[0][i]);
    // Longer mixed run from another seed, stall with en low too
    drive(1'b0, 1'b0, 1'b1, SEED_B);
    for (int i = 0; i < 600; i++)
      drive(($urandom % 4) != 0, ($urandom % 3) != 0, 1'b0, '0);
    repeat (4) drive(1'b0, 1'b1, 1'b0, '0);
    check(expq.size() == 0, "R5 queue drained", N'(expq.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule